// File: doc/BRIEF.md
# Interrupt Source Conditioning Controller

This block is the input stage of an interrupt controller with `NSRC` sources. Source 0 is the fast interrupt. Each raw source input passes through one sampling register. A per-source trigger mode then turns it into a pending bit. In the two level modes the pending bit follows the input, with polarity applied. In the two edge modes an edge sets a latch, which stays set until it is cleared. The pending vector, and that vector gated by a per-source mask, are presented to a downstream priority stage.

Software controls the stage through a small register port with a write strobe, an address, write data, a read strobe and combinational read data. Masks are changed through write-one-to-enable and write-one-to-disable commands. Edge latches can be forced set or cleared by command. Reading the normal vector register returns the current interrupt number, which the priority stage supplies on `cur_id` and `cur_vld`. The same read clears that one source's latch, unless fast forcing is enabled for that source. Reading the fast vector register clears the latch of source 0.

All pins are plain control and status signals. No stream is exchanged, so there is no valid/ready pair and no back-pressure. Register map, by word address: 0 enable command, 1 disable command, 2 latch set command, 3 latch clear command, 4 mask (read), 5 pending (read), 6 normal vector (read), 7 fast vector (read), 8+i mode of source i (read/write).

Top module: `irq_src_cond`

## Requirements
- R1: After reset every mask bit is 0, every edge latch is 0 and every mode reads 0 (high level). With all inputs low, `pend_vec` and `act_vec` are 0.
- R2: Mode code 00 (high level) makes the pending bit equal to the input value sampled at the previous clock edge. Mode code 01 (low level) makes it the inverse of that value. No latch is involved.
- R3: Mode code 10 (rising edge) or 11 (falling edge) sets the source's latch on the matching transition of the sampled input. The pending bit shows the latch two clock edges after the input changes and holds it until a clear.
- R4: Writing address 0 sets the mask bits at the positions of the data's 1 bits, and writing address 1 clears them. Zero bits leave the mask unchanged. The mask reads back at address 4.
- R5: `act_vec` equals the pending vector ANDed with the mask. The pending vector, also readable at address 5, reflects source activity whether the source is masked or not.
- R6: For a source in an edge mode, a 1 written to address 2 sets its latch and a 1 written to address 3 clears it.
- R7: Set and clear commands for a source in a level mode have no effect on its pending bit.
- R8: A read of address 6 returns `cur_id`. When `cur_vld` is high, the read clears the latch of source `cur_id` only.
- R9: The clear on a read of address 6 is suppressed when `ff_en` is set for the current source.
- R10: A read of address 7 returns 0 and clears the latch of source 0.
- R11: When a latch clear and a detected edge on the same source meet in one cycle, the latch ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Raw interrupt source inputs |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | NSRC | Write data |
| bus_re | input | 1 | Register read strobe |
| bus_rdata | output | NSRC | Combinational read data |
| cur_vld | input | 1 | A current interrupt exists |
| cur_id | input | clog2(NSRC) | Current interrupt number from the priority stage |
| ff_en | input | NSRC | Fast forcing enabled per source |
| pend_vec | output | NSRC | Pending bit per source |
| act_vec | output | NSRC | Pending bits gated by the mask |

## Verification
The assertions check four things on every cycle for every source:
- that level-mode pending tracks the previously sampled input with the programmed polarity;
- that a matching edge always produces a set latch on the following edge, whatever clear arrives with it;
- that enable and disable commands reach the mask;
- that a vector read leaves a fast-forced source pending.

Only the bench scenarios can show that a vector read clears exactly the current source and no other, and that set and clear commands leave level sources untouched. The same holds for the fast vector read clearing source 0 and for the mask gating of the active outputs. The bench does this by sweeping every source through all four modes.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  typedef enum logic [1:0] {
    TRG_HIGH = 2'b00,
    TRG_LOW  = 2'b01,
    TRG_RISE = 2'b10,
    TRG_FALL = 2'b11
  } trig_e;

  localparam int REG_ENA   = 0;
  localparam int REG_DIS   = 1;
  localparam int REG_SET   = 2;
  localparam int REG_CLR   = 3;
  localparam int REG_MASK  = 4;
  localparam int REG_PEND  = 5;
  localparam int REG_IVEC  = 6;
  localparam int REG_FVEC  = 7;
  localparam int REG_MODE0 = 8;
endpackage

// File: rtl/irq_src_slice.sv
module irq_src_slice
  import irq_src_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_i,
  input  logic [1:0] mode_i,
  input  logic       set_i,
  input  logic       clr_i,
  output logic       pend_o
);
  trig_e trg;
  logic  smp_q, prv_q, lat_q, lat_n;
  logic  edge_hit, inv;

  assign trg = trig_e'(mode_i);
  assign inv = mode_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= 1'b0;
      prv_q <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      smp_q <= src_i;
      prv_q <= smp_q;
      lat_q <= lat_n;
    end
  end

  // transition toward the active polarity
  assign edge_hit = (smp_q ^ inv) & ~(prv_q ^ inv);

  always_comb begin
    unique case (trg)
      TRG_RISE, TRG_FALL: begin
        // an edge outranks a simultaneous clear
        lat_n  = edge_hit | set_i | (lat_q & ~clr_i);
        pend_o = lat_q;
      end
      default: begin
        lat_n  = 1'b0;
        pend_o = smp_q ^ inv;
      end
    endcase
  end
endmodule

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_src_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int AW   = 5,
  parameter int IDW  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  input  logic [NSRC-1:0]      bus_wdata,
  input  logic                 bus_re,
  input  logic                 cur_vld,
  input  logic [IDW-1:0]       cur_id,
  input  logic [NSRC-1:0]      ff_en,
  input  logic [NSRC-1:0]      pend_i,
  output logic [NSRC-1:0]      mask_o,
  output logic [NSRC-1:0][1:0] mode_o,
  output logic [NSRC-1:0]      set_o,
  output logic [NSRC-1:0]      clr_o,
  output logic [NSRC-1:0]      rdata_o
);
  localparam logic [AW-1:0] AD_ENA  = AW'(REG_ENA);
  localparam logic [AW-1:0] AD_DIS  = AW'(REG_DIS);
  localparam logic [AW-1:0] AD_SET  = AW'(REG_SET);
  localparam logic [AW-1:0] AD_CLR  = AW'(REG_CLR);
  localparam logic [AW-1:0] AD_MASK = AW'(REG_MASK);
  localparam logic [AW-1:0] AD_PEND = AW'(REG_PEND);
  localparam logic [AW-1:0] AD_IVEC = AW'(REG_IVEC);
  localparam logic [AW-1:0] AD_FVEC = AW'(REG_FVEC);

  logic [NSRC-1:0]      mask_q;
  logic [NSRC-1:0][1:0] mode_q;
  logic                 iv_rd, fv_rd;

  assign iv_rd = bus_re && (bus_addr == AD_IVEC);
  assign fv_rd = bus_re && (bus_addr == AD_FVEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (bus_we && bus_addr == AD_ENA) begin
      mask_q <= mask_q | bus_wdata;
    end else if (bus_we && bus_addr == AD_DIS) begin
      mask_q <= mask_q & ~bus_wdata;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam logic [AW-1:0] AD_MODE = AW'(REG_MODE0 + i);
    logic auto_clr;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[i] <= TRG_HIGH;
      end else if (bus_we && bus_addr == AD_MODE) begin
        mode_q[i] <= bus_wdata[1:0];
      end
    end

    if (i == 0) begin : g_fast
      assign auto_clr = fv_rd ||
                        (iv_rd && cur_vld && cur_id == IDW'(i) && !ff_en[i]);
    end else begin : g_norm
      assign auto_clr = iv_rd && cur_vld && cur_id == IDW'(i) && !ff_en[i];
    end

    assign set_o[i] = bus_we && bus_addr == AD_SET && bus_wdata[i];
    assign clr_o[i] = (bus_we && bus_addr == AD_CLR && bus_wdata[i]) || auto_clr;
  end

  always_comb begin
    rdata_o = '0;
    if (bus_addr == AD_MASK)      rdata_o = mask_q;
    else if (bus_addr == AD_PEND) rdata_o = pend_i;
    else if (bus_addr == AD_IVEC) rdata_o = NSRC'(cur_id);
    else if (bus_addr == AD_FVEC) rdata_o = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (bus_addr == AW'(REG_MODE0 + k)) rdata_o = NSRC'(mode_q[k]);
    end
  end

  assign mask_o = mask_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond
  import irq_src_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int AW   = 5,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  input  logic            bus_re,
  output logic [NSRC-1:0] bus_rdata,
  input  logic            cur_vld,
  input  logic [IDW-1:0]  cur_id,
  input  logic [NSRC-1:0] ff_en,
  output logic [NSRC-1:0] pend_vec,
  output logic [NSRC-1:0] act_vec
);
  logic [NSRC-1:0]      mask_q;
  logic [NSRC-1:0][1:0] mode_q;
  logic [NSRC-1:0]      set_v, clr_v;

  irq_src_regs #(.NSRC(NSRC), .AW(AW), .IDW(IDW)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_re   (bus_re),
    .cur_vld  (cur_vld),
    .cur_id   (cur_id),
    .ff_en    (ff_en),
    .pend_i   (pend_vec),
    .mask_o   (mask_q),
    .mode_o   (mode_q),
    .set_o    (set_v),
    .clr_o    (clr_v),
    .rdata_o  (bus_rdata)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_slice
    irq_src_slice slice_i (
      .clk   (clk),
      .rst_n (rst_n),
      .src_i (src_in[i]),
      .mode_i(mode_q[i]),
      .set_i (set_v[i]),
      .clr_i (clr_v[i]),
      .pend_o(pend_vec[i])
    );
  end

  assign act_vec = pend_vec & mask_q;
endmodule

// File: rtl/irq_src_cond_chk.sv
module irq_src_cond_chk
  import irq_src_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int AW   = 5,
  parameter int IDW  = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NSRC-1:0]      src_in,
  input logic                 bus_we,
  input logic                 bus_re,
  input logic [AW-1:0]        bus_addr,
  input logic [NSRC-1:0]      bus_wdata,
  input logic                 cur_vld,
  input logic [IDW-1:0]       cur_id,
  input logic [NSRC-1:0]      ff_en,
  input logic [NSRC-1:0][1:0] mode_vec,
  input logic [NSRC-1:0]      mask_vec,
  input logic [NSRC-1:0]      pend_vec
);
  localparam logic [AW-1:0] AD_ENA  = AW'(REG_ENA);
  localparam logic [AW-1:0] AD_DIS  = AW'(REG_DIS);
  localparam logic [AW-1:0] AD_CLR  = AW'(REG_CLR);
  localparam logic [AW-1:0] AD_IVEC = AW'(REG_IVEC);

  // R4
  ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AD_ENA) |=> ((mask_vec & $past(bus_wdata)) == $past(bus_wdata)));

  // R4
  dis_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AD_DIS) |=> ((mask_vec & $past(bus_wdata)) == '0));

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    // R2
    lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_vec[i][1] && $past(rst_n)) |->
        (pend_vec[i] == ($past(src_in[i]) ^ mode_vec[i][0])));

    // R3 R11
    edge_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_vec[i][1] && $past(rst_n) && $past(rst_n, 2) &&
       ($past(src_in[i]) ^ mode_vec[i][0]) &&
       !($past(src_in[i], 2) ^ mode_vec[i][0])) |=>
        (pend_vec[i] || !mode_vec[i][1]));

    // R9
    ff_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr == AD_IVEC && cur_vld && cur_id == IDW'(i) && ff_en[i] &&
       mode_vec[i][1] && pend_vec[i] && !(bus_we && bus_addr == AD_CLR)) |=>
        (pend_vec[i] || !mode_vec[i][1]));
  end
endmodule

bind irq_src_cond irq_src_cond_chk #(.NSRC(NSRC), .AW(AW), .IDW(IDW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_in   (src_in),
  .bus_we   (bus_we),
  .bus_re   (bus_re),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .cur_vld  (cur_vld),
  .cur_id   (cur_id),
  .ff_en    (ff_en),
  .mode_vec (mode_q),
  .mask_vec (mask_q),
  .pend_vec (pend_vec)
);

// File: tb/irq_src_cond_tb_top.sv
module irq_src_cond_tb_top;
  localparam int NSRC = 8;
  localparam int AW   = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_in = '0;
  logic            bus_we = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [NSRC-1:0] bus_wdata = '0;
  logic            bus_re = 1'b0;
  logic [NSRC-1:0] bus_rdata;
  logic            cur_vld = 1'b0;
  logic [2:0]      cur_id = '0;
  logic [NSRC-1:0] ff_en = '0;
  logic [NSRC-1:0] pend_vec, act_vec;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_src_cond #(.NSRC(NSRC), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .cur_vld(cur_vld), .cur_id(cur_id),
    .ff_en(ff_en), .pend_vec(pend_vec), .act_vec(act_vec)
  );

  task automatic check(input string req, input logic [NSRC-1:0] got,
                       input logic [NSRC-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [NSRC-1:0] d);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [NSRC-1:0] d);
    bus_re = 1'b1; bus_addr = AW'(a);
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [NSRC-1:0] r;
    logic [NSRC-1:0] exp;
    logic exp_lat, prev, v;
    settle(3);
    rst_n = 1'b1;
    settle(2);

    // R1 reset state
    check("R1 pend", pend_vec, '0);
    check("R1 act", act_vec, '0);
    rd(4, r); check("R1 mask", r, '0);
    rd(8 + 3, r); check("R1 mode", r, '0);

    // R2 R3 sweep of every source through every mode, pattern 1,0,1
    for (int i = 0; i < NSRC; i++) begin
      for (int m = 0; m < 4; m++) begin
        src_in = '0; settle(3);
        wr(8 + i, NSRC'(m));
        wr(3, '1);
        exp_lat = 1'b0; prev = 1'b0;
        for (int k = 0; k < 3; k++) begin
          v = (k != 1);
          src_in[i] = v; settle(2);
          if (m == 2 && v && !prev) exp_lat = 1'b1;
          if (m == 3 && !v && prev) exp_lat = 1'b1;
          exp = '0;
          exp[i] = (m < 2) ? (v ^ m[0]) : exp_lat;
          check((m < 2) ? "R2 level" : "R3 edge", pend_vec, exp);
          prev = v;
        end
        check("R5 masked act", act_vec, '0);
        rd(5, r); check("R5 pend reg", r, exp);
        wr(8 + i, '0);
      end
    end
    src_in = '0; settle(3);

    // R6 R7 set and clear against edge and level sources
    wr(8 + 2, 2'b10);
    src_in[3] = 1'b1; settle(2);
    wr(2, 8'h0C); check("R6 set", pend_vec, 8'h0C);
    src_in[3] = 1'b0; settle(2);
    check("R7 set ignored", pend_vec, 8'h04);
    src_in[3] = 1'b1; settle(2);
    wr(3, 8'h0C); check("R7 clr ignored R6 clr", pend_vec, 8'h08);
    src_in[3] = 1'b0; settle(2);

    // R8 R9 R10 vector reads
    wr(8 + 0, 2'b10); wr(8 + 1, 2'b10); wr(8 + 5, 2'b10);
    wr(2, 8'h27); check("R6 set multi", pend_vec, 8'h27);
    cur_vld = 1'b1; cur_id = 3'd2;
    rd(6, r); check("R8 ivec value", r, 8'h02);
    check("R8 clear current only", pend_vec, 8'h23);
    cur_id = 3'd5; ff_en = 8'h20;
    rd(6, r); check("R9 ff suppress", pend_vec, 8'h23);
    ff_en = '0; cur_vld = 1'b0;
    rd(6, r); check("R8 no current", pend_vec, 8'h23);
    rd(7, r); check("R10 fvec value", r, '0);
    check("R10 fvec clear", pend_vec, 8'h22);

    // R4 R5 mask commands and gating
    wr(0, 8'hA5); rd(4, r); check("R4 enable", r, 8'hA5);
    wr(1, 8'h05); rd(4, r); check("R4 disable", r, 8'hA0);
    wr(0, 8'h00); rd(4, r); check("R4 zero no effect", r, 8'hA0);
    check("R5 act gate", act_vec, 8'h20);
    wr(1, 8'h20); check("R5 act masked", act_vec, 8'h00);
    check("R5 pend unmasked", pend_vec, 8'h22);
    rd(4, r); check("R4 others kept", r, 8'h80);

    // R11 edge beats clear in the same cycle
    wr(8 + 4, 2'b10); wr(2, 8'h10);
    src_in[4] = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(3); bus_wdata = 8'h10;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
    check("R11 edge wins", pend_vec & 8'h10, 8'h10);
    wr(3, 8'h10); check("R11 later clear", pend_vec & 8'h10, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule